// File: doc/BRIEF.md
# DRAM write-per-bit mask controller

This block is a synchronous model of the write-mask logic that sits beside a four-bit-wide DRAM array. The strobes of the memory interface are delivered to it as single-cycle event pulses (row strobe falling, row strobe rising, column strobe falling, write strobe falling). Alongside them come the sampled levels of the write strobe, a special-function select, a refresh marker and the data bus. For every write it produces a per-bit write enable that tells the array which of the four data bits may change.

Each row cycle is classified at its row-strobe fall. With the write strobe low, the row becomes a masked row: the special-function select picks either a one-row mask (normal mode) or a mask that is kept across later rows (persistent mode). The mask is taken from the data bus at the first write of the row, which happens at the later of the column-strobe fall and the write-strobe fall. A row opened with the write strobe high writes all bits, unless a persistent mask is in force. Refresh rows perform no writes. Opening a refresh row with the write strobe low while a persistent mask is held is a protocol error and is flagged.

Top module: `wpb_mask_ctl`

## Requirements
- R1: After synchronous reset, wr_valid, wpb_row, persist_on and proto_err are 0, and the first write of a row opened with we_lvl high has wr_en = 4'b1111.
- R2: At ras_fall with rfsh = 0 and we_lvl = 0, the row is masked (wpb_row = 1 from the next cycle until ras_rise): sf_sel = 1 selects persistent mode, sf_sel = 0 normal mode. With we_lvl = 1, or with rfsh = 1, wpb_row stays 0.
- R3: A write occurs at a cas_fall seen with we_lvl = 0 (early write), or at a we_fall that follows a cas_fall seen with we_lvl = 1 (delayed write). wr_valid is 1 for one cycle, in the cycle after that event.
- R4: In a masked row, the first write captures dq as the mask, and the mask applies to that write; bit i = 1 enables data bit i and 0 blocks it. Later writes in the same row reuse that mask, whatever is on dq.
- R5: A normal-mode mask lasts only until ras_rise; a later row opened with we_lvl high writes 4'b1111.
- R6: With no persistent mask held, a row opened with we_lvl high writes 4'b1111 on every write.
- R7: A persistent-mode capture sets persist_on = 1 and keeps the mask across rows; rows opened with we_lvl high then write with that mask while wpb_row = 0.
- R8: A later persistent-mode capture replaces the held mask. A normal-mode capture clears persist_on and, from then on, rows opened with we_lvl high write 4'b1111.
- R9: Refresh rows (rfsh = 1 at ras_fall) produce no writes and leave the held mask unchanged. proto_err pulses for one cycle after a refresh ras_fall with we_lvl = 0 while persist_on = 1, and it stays 0 otherwise.
- R10: wr_special reports sf_sel as sampled at the cas_fall of that write.
- R11: A pending column event (cas_fall with we_lvl = 1 and no write yet) is dropped at ras_rise and ras_fall; a we_fall in the next row with no new cas_fall gives no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_fall | input | 1 | Row strobe falling-edge pulse |
| ras_rise | input | 1 | Row strobe rising-edge pulse |
| cas_fall | input | 1 | Column strobe falling-edge pulse |
| we_fall | input | 1 | Write strobe falling-edge pulse |
| we_lvl | input | 1 | Sampled write-strobe level (0 = asserted low) |
| sf_sel | input | 1 | Sampled special-function select level |
| rfsh | input | 1 | Marks the row opened at ras_fall as a refresh row |
| dq | input | 4 | Sampled data bus |
| wr_valid | output | 1 | One-cycle pulse for each write |
| wr_en | output | 4 | Per-bit write enable for the write, 1 = write |
| wr_special | output | 1 | Special-function select taken at that write's column event |
| wpb_row | output | 1 | Current row is a masked row |
| persist_on | output | 1 | A persistent mask is held |
| proto_err | output | 1 | One-cycle pulse: refresh opened with write strobe low while persistent |

## Verification
The hardest state to reach is a persistent mask that has survived several rows, followed by a refresh row that opens with the write strobe low. Only then does the protocol error show, and only then can one see that the held mask survives the refresh. The stimulus builds this up in order: it loads a persistent mask, runs plain rows that must write with it, runs one legal refresh and one illegal refresh, and then runs a plain row to show that the held mask is unchanged. Delayed writes are produced by a column fall with the write strobe high, followed by a write-strobe fall. A pending column event that is left open across a row change checks that it is discarded.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

    localparam int DQ_W = 4;

    typedef enum logic [2:0] {
        ROW_IDLE  = 3'd0,
        ROW_PLAIN = 3'd1,
        ROW_NORM  = 3'd2,
        ROW_LOAD  = 3'd3,
        ROW_RFSH  = 3'd4
    } row_kind_e;

    typedef struct packed {
        logic            valid;
        logic [DQ_W-1:0] en;
        logic            special;
    } wr_out_t;

    function automatic row_kind_e decode_row(input logic rf, input logic we_l, input logic sf);
        if (rf)
            return ROW_RFSH;
        else if (!we_l)
            return sf ? ROW_LOAD : ROW_NORM;
        else
            return ROW_PLAIN;
    endfunction

    function automatic logic is_write_row(input row_kind_e k);
        return (k == ROW_PLAIN) || (k == ROW_NORM) || (k == ROW_LOAD);
    endfunction

    function automatic logic is_masked_row(input row_kind_e k);
        return (k == ROW_NORM) || (k == ROW_LOAD);
    endfunction

endpackage

// File: rtl/wpm_row_ctl.sv
module wpm_row_ctl
    import wpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ras_fall,
    input  logic      ras_rise,
    input  logic      we_lvl,
    input  logic      sf_sel,
    input  logic      rfsh,
    input  logic      persist_on,
    output row_kind_e kind,
    output logic      proto_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind      <= ROW_IDLE;
            proto_err <= 1'b0;
        end else begin
            proto_err <= 1'b0;
            if (ras_fall) begin
                kind <= decode_row(rfsh, we_lvl, sf_sel);
                if (rfsh && !we_lvl && persist_on)
                    proto_err <= 1'b1;
            end else if (ras_rise) begin
                kind <= ROW_IDLE;
            end
        end
    end

    // R9
    err_needs_persist_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(persist_on) && kind == ROW_RFSH));

    // R2
    masked_row_open_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && !rfsh && !we_lvl) |=> is_masked_row(kind));

endmodule

// File: rtl/wpm_col_trk.sv
module wpm_col_trk
    import wpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  row_kind_e kind,
    input  logic      ras_fall,
    input  logic      ras_rise,
    input  logic      cas_fall,
    input  logic      we_fall,
    input  logic      we_lvl,
    input  logic      sf_sel,
    output logic      evt,
    output logic      evt_sf
);

    logic cas_pend;
    logic pend_sf;
    logic row_edge;
    logic early_wr;
    logic late_wr;

    assign row_edge = ras_fall || ras_rise;
    assign early_wr = !row_edge && is_write_row(kind) && cas_fall && !we_lvl;
    assign late_wr  = !row_edge && is_write_row(kind) && !cas_fall && we_fall && cas_pend;
    assign evt      = early_wr || late_wr;
    assign evt_sf   = early_wr ? sf_sel : pend_sf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cas_pend <= 1'b0;
            pend_sf  <= 1'b0;
        end else if (row_edge) begin
            cas_pend <= 1'b0;
        end else if (is_write_row(kind) && cas_fall && we_lvl) begin
            cas_pend <= 1'b1;
            pend_sf  <= sf_sel;
        end else if (evt) begin
            cas_pend <= 1'b0;
        end
    end

    // R11
    pend_drop_chk: assert property (@(posedge clk) disable iff (rst)
        row_edge |=> !cas_pend);

    // R3
    late_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        late_wr |-> $past(cas_fall || cas_pend));

endmodule

// File: rtl/wpm_mask_sel.sv
module wpm_mask_sel
    import wpm_pkg::*;
#(
    parameter int DW = DQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  row_kind_e     kind,
    input  logic          ras_fall,
    input  logic          ras_rise,
    input  logic          evt,
    input  logic [DW-1:0] dq,
    output logic [DW-1:0] en,
    output logic          persist_on
);

    localparam logic [DW-1:0] ALL_ON = {DW{1'b1}};

    logic          taken;
    logic [DW-1:0] nmask;
    logic [DW-1:0] pmask;
    logic          first_cap;

    assign first_cap = evt && !taken && is_masked_row(kind);

    always_comb begin
        unique case (kind)
            ROW_NORM: en = taken ? nmask : dq;
            ROW_LOAD: en = taken ? pmask : dq;
            default:  en = persist_on ? pmask : ALL_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taken      <= 1'b0;
            nmask      <= ALL_ON;
            pmask      <= ALL_ON;
            persist_on <= 1'b0;
        end else if (ras_fall || ras_rise) begin
            taken <= 1'b0;
            if (ras_rise)
                nmask <= ALL_ON;
        end else if (first_cap) begin
            taken <= 1'b1;
            if (kind == ROW_NORM) begin
                nmask      <= dq;
                persist_on <= 1'b0;
            end else begin
                pmask      <= dq;
                persist_on <= 1'b1;
            end
        end
    end

    // R8
    persist_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(persist_on) |-> $past(kind == ROW_NORM && evt));

    // R7
    persist_enter_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(persist_on) |-> $past(kind == ROW_LOAD && evt));

    // R9
    refresh_keeps_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == ROW_RFSH && !ras_fall && !ras_rise) |=> $stable(pmask));

endmodule

// File: rtl/wpb_mask_ctl.sv
module wpb_mask_ctl
    import wpm_pkg::*;
#(
    parameter int DW = DQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_fall,
    input  logic          ras_rise,
    input  logic          cas_fall,
    input  logic          we_fall,
    input  logic          we_lvl,
    input  logic          sf_sel,
    input  logic          rfsh,
    input  logic [DW-1:0] dq,
    output logic          wr_valid,
    output logic [DW-1:0] wr_en,
    output logic          wr_special,
    output logic          wpb_row,
    output logic          persist_on,
    output logic          proto_err
);

    row_kind_e     kind;
    logic          evt;
    logic          evt_sf;
    logic [DW-1:0] en_now;
    wr_out_t       wr_q;

    wpm_row_ctl u_row (
        .clk        (clk),
        .rst        (rst),
        .ras_fall   (ras_fall),
        .ras_rise   (ras_rise),
        .we_lvl     (we_lvl),
        .sf_sel     (sf_sel),
        .rfsh       (rfsh),
        .persist_on (persist_on),
        .kind       (kind),
        .proto_err  (proto_err)
    );

    wpm_col_trk u_col (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .ras_fall (ras_fall),
        .ras_rise (ras_rise),
        .cas_fall (cas_fall),
        .we_fall  (we_fall),
        .we_lvl   (we_lvl),
        .sf_sel   (sf_sel),
        .evt      (evt),
        .evt_sf   (evt_sf)
    );

    wpm_mask_sel #(.DW(DW)) u_mask (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .ras_fall   (ras_fall),
        .ras_rise   (ras_rise),
        .evt        (evt),
        .dq         (dq),
        .en         (en_now),
        .persist_on (persist_on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '{valid: 1'b0, en: {DW{1'b1}}, special: 1'b0};
        end else begin
            wr_q.valid <= evt;
            if (evt) begin
                wr_q.en      <= en_now;
                wr_q.special <= evt_sf;
            end
        end
    end

    assign wr_valid   = wr_q.valid;
    assign wr_en      = wr_q.en;
    assign wr_special = wr_q.special;
    assign wpb_row    = is_masked_row(kind);

    // R6
    plain_all_on_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && $past(kind == ROW_PLAIN && !persist_on)) |-> (wr_en == {DW{1'b1}}));

    // R9
    no_refresh_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(is_write_row(kind)));

endmodule

// File: tb/wpb_mask_ctl_tb.sv
module wpb_mask_ctl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ras_fall = 0, ras_rise = 0, cas_fall = 0, we_fall = 0;
    logic       we_lvl = 1, sf_sel = 0, rfsh = 0;
    logic [3:0] dq = 4'h0;
    logic       wr_valid, wr_special, wpb_row, persist_on, proto_err;
    logic [3:0] wr_en;

    int n_chk = 0;
    int n_fail = 0;
    bit running = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wpb_mask_ctl u_dut (
        .clk(clk), .rst(rst), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .cas_fall(cas_fall), .we_fall(we_fall), .we_lvl(we_lvl), .sf_sel(sf_sel),
        .rfsh(rfsh), .dq(dq), .wr_valid(wr_valid), .wr_en(wr_en),
        .wr_special(wr_special), .wpb_row(wpb_row), .persist_on(persist_on),
        .proto_err(proto_err)
    );

    // reference model: row kinds 0 idle, 1 plain, 2 normal, 3 persistent load, 4 refresh
    int         m_kind = 0;
    bit         m_taken = 0, m_pon = 0, m_cpend = 0, m_csf = 0;
    logic [3:0] m_nmask = 4'hF, m_pmask = 4'hF;
    bit         x_valid = 0, x_sp = 0, x_err = 0;
    logic [3:0] x_en = 4'hF;

    always @(posedge clk) begin
        bit ev;
        if (rst) begin
            m_kind = 0; m_taken = 0; m_pon = 0; m_cpend = 0;
            m_nmask = 4'hF; m_pmask = 4'hF; x_valid = 0; x_err = 0; x_en = 4'hF; x_sp = 0;
        end else begin
            x_valid = 0; x_err = 0; ev = 0;
            if (ras_fall) begin
                m_cpend = 0; m_taken = 0;
                if (rfsh) begin
                    m_kind = 4;
                    if (m_pon && !we_lvl) x_err = 1;
                end else if (!we_lvl) m_kind = sf_sel ? 3 : 2;
                else m_kind = 1;
            end else if (ras_rise) begin
                m_kind = 0; m_cpend = 0; m_taken = 0; m_nmask = 4'hF;
            end else if (m_kind >= 1 && m_kind <= 3) begin
                if (cas_fall) begin
                    if (!we_lvl) begin ev = 1; x_sp = sf_sel; end
                    else begin m_cpend = 1; m_csf = sf_sel; end
                end else if (we_fall && m_cpend) begin
                    ev = 1; x_sp = m_csf; m_cpend = 0;
                end
                if (ev) begin
                    x_valid = 1;
                    if (m_kind == 2) begin
                        if (!m_taken) begin m_nmask = dq; m_taken = 1; m_pon = 0; end
                        x_en = m_nmask;
                    end else if (m_kind == 3) begin
                        if (!m_taken) begin m_pmask = dq; m_taken = 1; m_pon = 1; end
                        x_en = m_pmask;
                    end else begin
                        x_en = m_pon ? m_pmask : 4'hF;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            chk("R3 wr_valid", {3'b0, wr_valid}, {3'b0, x_valid});
            if (x_valid) begin
                chk("R4 wr_en", wr_en, x_en);
                chk("R10 wr_special", {3'b0, wr_special}, {3'b0, x_sp});
            end
            chk("R2 wpb_row", {3'b0, wpb_row}, {3'b0, (m_kind == 2 || m_kind == 3)});
            chk("R7 persist_on", {3'b0, persist_on}, {3'b0, m_pon});
            chk("R9 proto_err", {3'b0, proto_err}, {3'b0, x_err});
        end
    end

    // one cycle of stimulus; pulses are cleared afterwards
    task automatic cyc(input bit rf_, input bit rr_, input bit cf_, input bit wf_,
                       input bit wl_, input bit sf_, input logic [3:0] d_, input bit rs_);
        ras_fall = rf_; ras_rise = rr_; cas_fall = cf_; we_fall = wf_;
        we_lvl = wl_; sf_sel = sf_; dq = d_; rfsh = rs_;
        @(negedge clk);
        ras_fall = 0; ras_rise = 0; cas_fall = 0; we_fall = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, we_lvl, sf_sel, dq, 0);
    endtask

    task automatic open_row(input bit wl, input bit sf, input bit rs);
        cyc(1, 0, 0, 0, wl, sf, 4'h0, rs); idle(1);
    endtask

    task automatic close_row();
        cyc(0, 1, 0, 0, 1, 0, 4'h0, 0); idle(1);
    endtask

    task automatic early_wr(input bit sf, input logic [3:0] d);
        cyc(0, 0, 1, 0, 0, sf, d, 0);
    endtask

    task automatic late_wr(input bit sf, input logic [3:0] d);
        cyc(0, 0, 1, 0, 1, sf, 4'h0, 0);
        idle(1);
        cyc(0, 0, 0, 1, 0, 0, d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 wr_valid", {3'b0, wr_valid}, 4'h0);
        chk("R1 wpb_row", {3'b0, wpb_row}, 4'h0);
        chk("R1 persist_on", {3'b0, persist_on}, 4'h0);
        chk("R1 proto_err", {3'b0, proto_err}, 4'h0);
        running = 1;

        // R1 R6 plain row, delayed write
        open_row(1, 0, 0);
        late_wr(0, 4'h2);
        chk("R1 R6 plain wr_en", wr_en, 4'hF);
        close_row();

        // R4 normal masked row, early writes in page mode
        open_row(0, 0, 0);
        chk("R2 normal row", {3'b0, wpb_row}, 4'h1);
        early_wr(0, 4'b0101);
        chk("R4 captured mask", wr_en, 4'b0101);
        idle(1);
        early_wr(0, 4'b1111);
        chk("R4 reused mask", wr_en, 4'b0101);
        close_row();

        // R5 next plain row writes all bits
        open_row(1, 0, 0);
        early_wr(0, 4'h0);
        chk("R5 mask cleared", wr_en, 4'hF);
        close_row();

        // R3 R10 delayed write in masked row
        open_row(0, 0, 0);
        late_wr(1, 4'b0011);
        chk("R3 delayed valid", {3'b0, wr_valid}, 4'h1);
        chk("R10 special", {3'b0, wr_special}, 4'h1);
        chk("R4 delayed mask", wr_en, 4'b0011);
        close_row();

        // R11 pending column dropped at row change
        open_row(1, 0, 0);
        cyc(0, 0, 1, 0, 1, 0, 4'h0, 0);
        close_row();
        open_row(1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 4'h0, 0);
        chk("R11 no write", {3'b0, wr_valid}, 4'h0);
        close_row();

        // R7 persistent load and reuse across rows
        open_row(0, 1, 0);
        early_wr(0, 4'b1001);
        chk("R7 load mask", wr_en, 4'b1001);
        close_row();
        chk("R7 persist held", {3'b0, persist_on}, 4'h1);
        for (int r = 0; r < 2; r++) begin
            open_row(1, 0, 0);
            chk("R7 plain row unmasked flag", {3'b0, wpb_row}, 4'h0);
            late_wr(0, 4'hF);
            chk("R7 persistent use", wr_en, 4'b1001);
            close_row();
        end

        // R9 refresh rows
        open_row(1, 0, 1);
        early_wr(0, 4'h0);
        chk("R9 no refresh write", {3'b0, wr_valid}, 4'h0);
        close_row();
        cyc(1, 0, 0, 0, 0, 0, 4'h0, 1);
        chk("R9 error pulse", {3'b0, proto_err}, 4'h1);
        idle(1);
        chk("R9 error one cycle", {3'b0, proto_err}, 4'h0);
        close_row();
        open_row(1, 0, 0);
        early_wr(0, 4'h0);
        chk("R9 mask kept", wr_en, 4'b1001);
        close_row();

        // R8 replace, then exit via normal capture
        open_row(0, 1, 0);
        early_wr(0, 4'b0110);
        close_row();
        open_row(1, 0, 0);
        early_wr(0, 4'h0);
        chk("R8 replaced mask", wr_en, 4'b0110);
        close_row();
        open_row(0, 0, 0);
        early_wr(0, 4'b1100);
        close_row();
        chk("R8 persist cleared", {3'b0, persist_on}, 4'h0);
        open_row(1, 0, 0);
        early_wr(0, 4'h0);
        chk("R8 all on", wr_en, 4'hF);
        close_row();

        // R9 no error without persistent mask
        cyc(1, 0, 0, 0, 0, 0, 4'h0, 1);
        chk("R9 no error", {3'b0, proto_err}, 4'h0);
        close_row();

        idle(2);
        running = 0;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule